// File: doc/BRIEF.md
# Asymmetric RAM with Wide Read Port

A simple dual-port synchronous memory whose write side is narrow and whose read side is wider by a power of two. Software or a producer fills the array one narrow word at a time. A consumer then fetches several neighbouring narrow words in a single read. The ratio between the two ports is `2**SHIFT`. A wide read at row address `R` gathers the narrow locations `R*2**SHIFT` up to `R*2**SHIFT + 2**SHIFT - 1`. The lowest of these locations lands in the most significant lane of the result.

Each port has its own clock, and both ports may run from one shared clock. Read data is registered on the read clock. The memory array itself is not reset. Only the read output register is cleared by the active-low asynchronous reset.

Top module: `asym_ram_wide_rd`

## Requirements
- R1: The read word is `DW << SHIFT` bits wide. Lane k occupies bits `[(k+1)*DW-1 : k*DW]`. SHIFT values of 1 and 2 are supported.
- R2: The write address has AW bits and the read address has `AW-SHIFT` bits. A read at row R returns narrow locations `R*2**SHIFT` through `R*2**SHIFT + 2**SHIFT - 1`.
- R3: Narrow address `R*2**SHIFT + j` lands in lane `2**SHIFT-1-j`, so the lowest address is in the top lane. For example, with DW=8 and SHIFT=2, writing 0xde, 0xad, 0xbe, 0xef to narrow 0x84..0x87 and reading row 0x21 yields 0xdeadbeef.
- R4: Read data is registered. A new read address shows on `rdata_o` one read-clock edge after it is presented, and not before that edge.
- R5: A write takes place only on a write-clock edge with `we_i` high. Address and data presented with `we_i` low leave the contents unchanged.
- R6: When a read row covers a narrow location written on the same shared-clock edge, the read returns the old value for that lane. The new value is returned by the next read.
- R7: While `rst_ni` is low, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read register |
| we_i | input | 1 | Write enable |
| waddr_i | input | AW | Narrow write address |
| wdata_i | input | DW | Narrow write data |
| raddr_i | input | AW-SHIFT | Wide read row address |
| rdata_o | output | DW<<SHIFT | Registered wide read data |

## Verification
The bench targets lane ordering first. It fills the whole array with address-dependent patterns and reads every row in two configurations, SHIFT=2 and SHIFT=1. A design with the lanes reversed, or with the row taken from the wrong address bits, would return words whose bytes are swapped or come from a neighbouring row. A write attempt with `we_i` low is followed by a readback, which exposes any design that ignores the enable. The bench also probes just before and just after the read edge. A combinational read path would show the new word early. A same-edge write into the row being read must still return the old lane, so a design that forwards the new data fails that check.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;
  // lowest narrow offset within a row maps to the top lane
  function automatic int lane_of(int off, int n_lanes);
    return n_lanes - 1 - off;
  endfunction
endpackage

// File: rtl/asym_ram_wr_dec.sv
module asym_ram_wr_dec #(
  parameter int SHIFT  = 2,
  localparam int NLANE = 1 << SHIFT
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SHIFT-1:0] off_i,
  output logic [NLANE-1:0] lane_we_o
);
  import asym_ram_pkg::*;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign lane_we_o[k] = we_i && (lane_of(int'(off_i), NLANE) == k);
  end

  // R5
  wr_single_lane_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    we_i |-> $countones(lane_we_o) == 1);
  // R5
  no_idle_write_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !we_i |-> lane_we_o == '0);
endmodule

// File: rtl/asym_ram_lane.sv
module asym_ram_lane #(
  parameter int DW = 8,
  parameter int RW = 8,
  localparam int DEPTH = 1 << RW
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wrow_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] rrow_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[wrow_i] <= wdata_i;
  end

  // nonblocking read: same-edge write is not visible (old data)
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[rrow_i];
  end

  // R5
  wr_known_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown({wrow_i, wdata_i}));
endmodule

// File: rtl/asym_ram_wide_rd.sv
module asym_ram_wide_rd #(
  parameter int AW    = 10,
  parameter int DW    = 8,
  parameter int SHIFT = 2,
  localparam int NLANE = 1 << SHIFT,
  localparam int RW    = AW - SHIFT,
  localparam int RDW   = DW << SHIFT
) (
  input  logic           wclk_i,
  input  logic           rclk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RW-1:0]  raddr_i,
  output logic [RDW-1:0] rdata_o
);
  logic [NLANE-1:0] lane_we;

  asym_ram_wr_dec #(.SHIFT(SHIFT)) i_wr_dec (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .off_i     (waddr_i[SHIFT-1:0]),
    .lane_we_o (lane_we)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_bank
    asym_ram_lane #(.DW(DW), .RW(RW)) i_lane (
      .wclk_i  (wclk_i),
      .rclk_i  (rclk_i),
      .rst_ni  (rst_ni),
      .we_i    (lane_we[k]),
      .wrow_i  (waddr_i[AW-1:SHIFT]),
      .wdata_i (wdata_i),
      .rrow_i  (raddr_i),
      .rdata_o (rdata_o[k*DW +: DW])
    );
  end

  // R7
  rst_clear_chk: assert property (@(posedge rclk_i)
    !rst_ni |-> rdata_o == '0);
  // R4
  rd_addr_known_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !$isunknown(raddr_i));
endmodule

// File: tb/test_asym_ram_wide_rd.sv
module test_asym_ram_wide_rd;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // config A: AW=8 DW=8 SHIFT=2 ; config B: AW=6 DW=18 SHIFT=1
  logic        we_a = 1'b0;
  logic [7:0]  waddr_a = '0;
  logic [7:0]  wdata_a = '0;
  logic [5:0]  raddr_a = '0;
  logic [31:0] rdata_a;
  logic        we_b = 1'b0;
  logic [5:0]  waddr_b = '0;
  logic [17:0] wdata_b = '0;
  logic [4:0]  raddr_b = '0;
  logic [35:0] rdata_b;

  asym_ram_wide_rd #(.AW(8), .DW(8), .SHIFT(2)) i_asym_ram_wide_rd (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .we_i(we_a),
    .waddr_i(waddr_a), .wdata_i(wdata_a), .raddr_i(raddr_a), .rdata_o(rdata_a));

  asym_ram_wide_rd #(.AW(6), .DW(18), .SHIFT(1)) i_asym_ram_wide_rd_s1 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .we_i(we_b),
    .waddr_i(waddr_b), .wdata_i(wdata_b), .raddr_i(raddr_b), .rdata_o(rdata_b));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0]  sh_a [256];
  logic [17:0] sh_b [64];

  function automatic logic [31:0] exp_a(int r);
    logic [31:0] e;
    for (int k = 0; k < 4; k++) e[k*8 +: 8] = sh_a[r*4 + 3 - k];
    return e;
  endfunction

  function automatic logic [35:0] exp_b(int r);
    logic [35:0] e;
    for (int k = 0; k < 2; k++) e[k*18 +: 18] = sh_b[r*2 + 1 - k];
    return e;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(int a, logic [7:0] d);
    @(negedge clk); we_a = 1'b1; waddr_a = 8'(a); wdata_a = d;
    @(negedge clk); we_a = 1'b0;
    sh_a[a] = d;
  endtask

  task automatic wr_b(int a, logic [17:0] d);
    @(negedge clk); we_b = 1'b1; waddr_b = 6'(a); wdata_b = d;
    @(negedge clk); we_b = 1'b0;
    sh_b[a] = d;
  endtask

  task automatic rd_a(int r, string req);
    @(negedge clk); raddr_a = 6'(r);
    @(negedge clk); check(req, 64'(rdata_a), 64'(exp_a(r)));
  endtask

  task automatic rd_b(int r, string req);
    @(negedge clk); raddr_b = 5'(r);
    @(negedge clk); check(req, 64'(rdata_b), 64'(exp_b(r)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WD_LIMIT; i++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] old_w;
    repeat (3) @(negedge clk);
    // R7: reset clears read registers
    check("R7", 64'(rdata_a), 64'h0);
    check("R7", 64'(rdata_b), 64'h0);
    rst_n = 1'b1;

    // R1 R2 R3: full sweep, config A (SHIFT=2)
    for (int a = 0; a < 256; a++) wr_a(a, 8'((a * 37 + 11) ^ (a >> 3)));
    for (int r = 0; r < 64; r++) rd_a(r, "R2");
    // R1 R2 R3: full sweep, config B (SHIFT=1)
    for (int a = 0; a < 64; a++) wr_b(a, 18'((a * 2731 + 97) ^ (a << 11)));
    for (int r = 0; r < 32; r++) rd_b(r, "R1");

    // R3: worked examples
    wr_a(8'h84, 8'hde); wr_a(8'h85, 8'had); wr_a(8'h86, 8'hbe); wr_a(8'h87, 8'hef);
    @(negedge clk); raddr_a = 6'h21;
    @(negedge clk); check("R3", 64'(rdata_a), 64'hdeadbeef);
    wr_b(2, 18'h0dead); wr_b(3, 18'h0beef);
    @(negedge clk); raddr_b = 5'd1;
    @(negedge clk); check("R3", 64'(rdata_b), (64'h0dead << 18) | 64'h0beef);

    // R5: address and data with enable low change nothing
    @(negedge clk); we_a = 1'b0; waddr_a = 8'h85; wdata_a = 8'h00;
    we_b = 1'b0; waddr_b = 6'd3; wdata_b = 18'h3ffff;
    @(negedge clk);
    @(negedge clk); check("R5", 64'(rdata_a), 64'hdeadbeef);
    check("R5", 64'(rdata_b), (64'h0dead << 18) | 64'h0beef);

    // R4: output changes only at the read edge
    @(negedge clk); raddr_a = 6'd5;
    #1 check("R4", 64'(rdata_a), 64'hdeadbeef);
    @(negedge clk); check("R4", 64'(rdata_a), 64'(exp_a(5)));

    // R6: same-edge write into the row being read returns old lane
    old_w = exp_a(5);
    @(negedge clk); raddr_a = 6'd5; we_a = 1'b1; waddr_a = 8'd21; wdata_a = 8'h5a;
    @(negedge clk); we_a = 1'b0; sh_a[21] = 8'h5a;
    check("R6", 64'(rdata_a), 64'(old_w));
    @(negedge clk); check("R6", 64'(rdata_a), 64'(exp_a(5)));
    check("R6", 64'(exp_a(5) >> 16 & 32'hff), 64'h5a);

    finish_run();
  end
endmodule